// File: doc/BRIEF.md
# Accumulator Computer with Two Loop-Counter Registers

This block is a small 8-bit accumulator computer with a 16-byte memory. Each instruction is one byte. The upper nibble selects the operation and the lower nibble is either a memory address or a 4-bit immediate. A microcode sequencer runs every instruction in steps: two fetch steps, then up to three execute steps.

Besides the accumulator, the B register, the add/subtract unit and the output register, the machine has two counting registers, I and J. Each can decrement itself without using the ALU, and each reports its own zero and carry result. A single flags register holds whichever of these results was produced last, so a conditional jump can test the ALU or a loop counter. The control word that drives all of this has 25 lines.

The memory is filled through a preload port while reset is held. After reset is released, execution starts at address 0. A two-loop factorial, which multiplies by repeated addition, fits in the 16 bytes and leaves N! in the accumulator and in the output register.

Top module: `loopcnt_cpu`

## Requirements
- R1: While reset is held, out_val, acc_val, zero_flag, carry_flag and halted are all 0.
- R2: A pl_we write while rst_n is low stores pl_data at pl_addr. After reset is released, execution begins at address 0, and memory keeps its contents across reset.
- R3: LDA n loads memory[n] into the accumulator. LDIA k loads the zero-extended immediate. STA n stores the accumulator to memory[n]. out_val changes only on OUT, which copies the accumulator. NOP (0) and the reserved code D change no visible state.
- R4: ADD n and SUB n write (A ± memory[n]) mod 256 to the accumulator and latch the flags. zero_flag is set when the result is 0. carry_flag is the carry out for ADD, and for SUB it is 1 when A ≥ operand. Only ADD, SUB, DECI and DECJ change the flags.
- R5: JMP n always jumps to n. JC n jumps only when the latched carry flag is 1. JZ n jumps only when the latched zero flag is 1.
- R6: DECI and DECJ decrement I or J modulo 256. They set zero_flag when the result is 0 and set carry_flag when the old value was not 0. A following JZ uses this flag, not the last ALU flag.
- R7: LDI n loads memory[n] into I. MVIJ copies I into J.
- R8: HLT raises halted. From then on, halted stays 1 and no register changes until the next reset.
- R9: The factorial program (0 LDI 15, 1 LDA 15, 2 DECI, 3 JZ 12, 4 STA 14, 5 MVIJ, 6 DECJ, 7 JZ 2, 8 ADD 14, 9 DECJ, 10 JZ 2, 11 JMP 8, 12 OUT, 13 HLT) with N at address 15 halts with N! in acc_val and in out_val, for N from 1 to 5.
- R10: Opcode encoding: NOP=0, LDA=1, ADD=2, SUB=3, STA=4, LDIA=5, JMP=6, JC=7, JZ=8, DECI=9, DECJ=A, LDI=B, MVIJ=C, reserved=D, OUT=E, HLT=F. At most one source drives the internal bus in any step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; also enables preload |
| pl_we | input | 1 | Preload write strobe (honoured only in reset) |
| pl_addr | input | 4 | Preload address |
| pl_data | input | 8 | Preload data |
| out_val | output | 8 | Output register |
| acc_val | output | 8 | Accumulator |
| zero_flag | output | 1 | Latched zero flag |
| carry_flag | output | 1 | Latched carry flag |
| halted | output | 1 | Set by HLT |

## Verification
The add/subtract path is swept over every pair drawn from a set of edge operands: 0, 1, a small value, 0x7F, 0x80 and 0xFF. This sweep separates wrap-around from plain sums, borrow from no-borrow, and a zero result from a nonzero one. After each run, the chained JC/JZ branches show that the branches read the latched flags.

A counting loop driven by DECJ is run for every start value from 0 to 12. Start value 0 tests the wrap of the counter through 255. The loop's ADD sets the ALU flags just before each DECJ, so the loop exits correctly only if JZ reads the counter's flag.

DECI is tried at 0, 1, 2 and 255 to pin down its zero and carry results. The factorial program is run for N from 1 to 5, and after the N=5 run the outputs are watched to confirm that the halt freezes them.

// File: rtl/lcc_pkg.sv
package lcc_pkg;

    localparam int CPU_DW  = 8;
    localparam int CPU_AW  = 4;
    localparam int STEPS   = 5;
    localparam int STW     = $clog2(STEPS);

    typedef enum logic [3:0] {
        OP_NOP  = 4'h0,
        OP_LDA  = 4'h1,
        OP_ADD  = 4'h2,
        OP_SUB  = 4'h3,
        OP_STA  = 4'h4,
        OP_LDIA = 4'h5,
        OP_JMP  = 4'h6,
        OP_JC   = 4'h7,
        OP_JZ   = 4'h8,
        OP_DECI = 4'h9,
        OP_DECJ = 4'hA,
        OP_LDI  = 4'hB,
        OP_MVIJ = 4'hC,
        OP_RSV  = 4'hD,
        OP_OUT  = 4'hE,
        OP_HLT  = 4'hF
    } opcode_e;

    // Control word: bus sources, load enables and special actions
    typedef struct packed {
        logic pc_oe;
        logic ir_oe;
        logic ram_oe;
        logic a_oe;
        logic alu_oe;
        logic i_oe;
        logic j_oe;
        logic mar_ld;
        logic ir_ld;
        logic ram_we;
        logic a_ld;
        logic b_ld;
        logic pc_ld;
        logic pc_inc;
        logic out_ld;
        logic i_ld;
        logic j_ld;
        logic i_inc;
        logic i_dec;
        logic j_inc;
        logic j_dec;
        logic alu_sub;
        logic alu_flags;
        logic halt;
        logic step_clr;
    } ctrl_t;

endpackage

// File: rtl/lcc_alu.sv
module lcc_alu #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] res,
    output logic         carry,
    output logic         zero
);
    logic [W:0] sum;

    always_comb begin
        if (sub) begin
            sum = {1'b0, a} + {1'b0, ~b} + (W+1)'(1);
        end else begin
            sum = {1'b0, a} + {1'b0, b};
        end
        res   = sum[W-1:0];
        carry = sum[W];
        zero  = (sum[W-1:0] == '0);
    end
endmodule

// File: rtl/lcc_counter.sv
module lcc_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         inc,
    input  logic         dec,
    output logic [W-1:0] val,
    output logic         nz,
    output logic         nc
);
    logic [W-1:0] val_d, val_q;

    always_comb begin
        val_d = val_q;
        nz    = 1'b0;
        nc    = 1'b0;
        if (ld) begin
            val_d = ld_val;
        end else if (inc) begin
            {nc, val_d} = {1'b0, val_q} + (W+1)'(1);
            nz          = (val_d == '0);
        end else if (dec) begin
            val_d = val_q - W'(1);
            nz    = (val_d == '0);
            nc    = (val_q != '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val_q <= '0;
        end else begin
            val_q <= val_d;
        end
    end

    assign val = val_q;
endmodule

// File: rtl/lcc_ram.sv
module lcc_ram #(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_d [DEPTH];
    logic [DW-1:0] mem_q [DEPTH];

    always_comb begin
        for (int k = 0; k < DEPTH; k++) begin
            mem_d[k] = mem_q[k];
        end
        if (we) begin
            mem_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        for (int k = 0; k < DEPTH; k++) begin
            mem_q[k] <= mem_d[k];
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/lcc_ctrl.sv
module lcc_ctrl
    import lcc_pkg::*;
(
    input  logic [3:0]     op,
    input  logic [STW-1:0] step,
    input  logic           zf,
    input  logic           cf,
    output ctrl_t          cw
);
    opcode_e opc;

    always_comb begin
        opc = opcode_e'(op);
        cw  = '0;
        if (step == STW'(0)) begin
            cw.pc_oe  = 1'b1;
            cw.mar_ld = 1'b1;
        end else if (step == STW'(1)) begin
            cw.ram_oe = 1'b1;
            cw.ir_ld  = 1'b1;
            cw.pc_inc = 1'b1;
        end else begin
            unique case (opc)
                OP_LDA, OP_LDI: begin
                    if (step == STW'(2)) begin
                        cw.ir_oe  = 1'b1;
                        cw.mar_ld = 1'b1;
                    end else begin
                        cw.ram_oe   = 1'b1;
                        cw.a_ld     = (opc == OP_LDA);
                        cw.i_ld     = (opc == OP_LDI);
                        cw.step_clr = 1'b1;
                    end
                end
                OP_ADD, OP_SUB: begin
                    if (step == STW'(2)) begin
                        cw.ir_oe  = 1'b1;
                        cw.mar_ld = 1'b1;
                    end else if (step == STW'(3)) begin
                        cw.ram_oe = 1'b1;
                        cw.b_ld   = 1'b1;
                    end else begin
                        cw.alu_oe    = 1'b1;
                        cw.alu_sub   = (opc == OP_SUB);
                        cw.alu_flags = 1'b1;
                        cw.a_ld      = 1'b1;
                        cw.step_clr  = 1'b1;
                    end
                end
                OP_STA: begin
                    if (step == STW'(2)) begin
                        cw.ir_oe  = 1'b1;
                        cw.mar_ld = 1'b1;
                    end else begin
                        cw.a_oe     = 1'b1;
                        cw.ram_we   = 1'b1;
                        cw.step_clr = 1'b1;
                    end
                end
                OP_LDIA: begin
                    cw.ir_oe    = 1'b1;
                    cw.a_ld     = 1'b1;
                    cw.step_clr = 1'b1;
                end
                OP_JMP, OP_JC, OP_JZ: begin
                    if ((opc == OP_JMP) || (opc == OP_JC && cf) || (opc == OP_JZ && zf)) begin
                        cw.ir_oe = 1'b1;
                        cw.pc_ld = 1'b1;
                    end
                    cw.step_clr = 1'b1;
                end
                OP_DECI: begin
                    cw.i_dec    = 1'b1;
                    cw.step_clr = 1'b1;
                end
                OP_DECJ: begin
                    cw.j_dec    = 1'b1;
                    cw.step_clr = 1'b1;
                end
                OP_MVIJ: begin
                    cw.i_oe     = 1'b1;
                    cw.j_ld     = 1'b1;
                    cw.step_clr = 1'b1;
                end
                OP_OUT: begin
                    cw.a_oe     = 1'b1;
                    cw.out_ld   = 1'b1;
                    cw.step_clr = 1'b1;
                end
                OP_HLT: begin
                    cw.halt = 1'b1;
                end
                default: begin
                    cw.step_clr = 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/loopcnt_cpu.sv
module loopcnt_cpu
    import lcc_pkg::*;
#(
    parameter int DW = CPU_DW,
    parameter int AW = CPU_AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pl_we,
    input  logic [AW-1:0] pl_addr,
    input  logic [DW-1:0] pl_data,
    output logic [DW-1:0] out_val,
    output logic [DW-1:0] acc_val,
    output logic          zero_flag,
    output logic          carry_flag,
    output logic          halted
);
    localparam int NCTR = 2;
    localparam int OPW  = DW - AW;

    typedef struct packed {
        logic [AW-1:0]  pc;
        logic [AW-1:0]  mar;
        logic [DW-1:0]  ir;
        logic [DW-1:0]  a;
        logic [DW-1:0]  b;
        logic [DW-1:0]  outr;
        logic           zf;
        logic           cf;
        logic           halt;
        logic [STW-1:0] step;
    } state_t;

    state_t s_d, s_q;
    ctrl_t  cw_raw, cw;

    logic [DW-1:0] bus;
    logic [DW-1:0] ram_rd;
    logic [DW-1:0] alu_res;
    logic          alu_c, alu_z;
    logic          ram_we;
    logic [AW-1:0] ram_wa;
    logic [DW-1:0] ram_wd;

    logic [DW-1:0]   ctr_val [NCTR];
    logic [NCTR-1:0] ctr_ld, ctr_inc, ctr_dec, ctr_z, ctr_c;

    // Signals observed by the bound checker
    logic       flag_upd;
    logic       out_ld;
    logic [6:0] bus_oe;

    lcc_ctrl u_ctrl (
        .op   (s_q.ir[DW-1 -: 4]),
        .step (s_q.step),
        .zf   (s_q.zf),
        .cf   (s_q.cf),
        .cw   (cw_raw)
    );

    // A halted machine asserts no control line
    assign cw = s_q.halt ? '0 : cw_raw;

    lcc_alu #(.W(DW)) u_alu (
        .a     (s_q.a),
        .b     (s_q.b),
        .sub   (cw.alu_sub),
        .res   (alu_res),
        .carry (alu_c),
        .zero  (alu_z)
    );

    assign ram_we = (!rst_n && pl_we) || cw.ram_we;
    assign ram_wa = !rst_n ? pl_addr : s_q.mar;
    assign ram_wd = !rst_n ? pl_data : bus;

    lcc_ram #(.DW(DW), .AW(AW)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_wa),
        .wdata (ram_wd),
        .raddr (s_q.mar),
        .rdata (ram_rd)
    );

    assign ctr_ld  = {cw.j_ld,  cw.i_ld};
    assign ctr_inc = {cw.j_inc, cw.i_inc};
    assign ctr_dec = {cw.j_dec, cw.i_dec};

    for (genvar g = 0; g < NCTR; g++) begin : g_ctr
        lcc_counter #(.W(DW)) u_ctr (
            .clk    (clk),
            .rst_n  (rst_n),
            .ld     (ctr_ld[g]),
            .ld_val (bus),
            .inc    (ctr_inc[g]),
            .dec    (ctr_dec[g]),
            .val    (ctr_val[g]),
            .nz     (ctr_z[g]),
            .nc     (ctr_c[g])
        );
    end

    assign bus_oe   = {cw.pc_oe, cw.ir_oe, cw.ram_oe, cw.a_oe, cw.alu_oe, cw.i_oe, cw.j_oe};
    assign flag_upd = cw.alu_flags | (|ctr_inc) | (|ctr_dec);
    assign out_ld   = cw.out_ld;

    always_comb begin
        bus = '0;
        if (cw.pc_oe)  bus = {{OPW{1'b0}}, s_q.pc};
        if (cw.ir_oe)  bus = {{OPW{1'b0}}, s_q.ir[AW-1:0]};
        if (cw.ram_oe) bus = ram_rd;
        if (cw.a_oe)   bus = s_q.a;
        if (cw.alu_oe) bus = alu_res;
        if (cw.i_oe)   bus = ctr_val[0];
        if (cw.j_oe)   bus = ctr_val[1];
    end

    always_comb begin
        s_d = s_q;
        if (cw.mar_ld) s_d.mar  = bus[AW-1:0];
        if (cw.ir_ld)  s_d.ir   = bus;
        if (cw.a_ld)   s_d.a    = bus;
        if (cw.b_ld)   s_d.b    = bus;
        if (cw.out_ld) s_d.outr = bus;
        if (cw.pc_ld) begin
            s_d.pc = bus[AW-1:0];
        end else if (cw.pc_inc) begin
            s_d.pc = s_q.pc + AW'(1);
        end
        if (cw.alu_flags) begin
            s_d.zf = alu_z;
            s_d.cf = alu_c;
        end
        for (int k = 0; k < NCTR; k++) begin
            if (ctr_inc[k] || ctr_dec[k]) begin
                s_d.zf = ctr_z[k];
                s_d.cf = ctr_c[k];
            end
        end
        if (cw.halt) s_d.halt = 1'b1;
        if (!s_q.halt) begin
            if (cw.step_clr || s_q.step == STW'(STEPS - 1)) begin
                s_d.step = '0;
            end else begin
                s_d.step = s_q.step + STW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign out_val    = s_q.outr;
    assign acc_val    = s_q.a;
    assign zero_flag  = s_q.zf;
    assign carry_flag = s_q.cf;
    assign halted     = s_q.halt;
endmodule

// File: rtl/loopcnt_cpu_chk.sv
module loopcnt_cpu_chk #(
    parameter int DW  = 8,
    parameter int STW = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           halted,
    input logic [DW-1:0]  out_val,
    input logic [DW-1:0]  acc_val,
    input logic           zero_flag,
    input logic           carry_flag,
    input logic           flag_upd,
    input logic           out_ld,
    input logic [6:0]     bus_oe,
    input logic [STW-1:0] step
);
    a_r8_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    a_r8_halt_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> ($stable(out_val) && $stable(acc_val) && $stable({zero_flag, carry_flag})));

    a_r4_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_upd |=> $stable({zero_flag, carry_flag}));

    a_r3_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !out_ld |=> $stable(out_val));

    a_r10_one_bus_driver: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bus_oe));

    a_r10_step_range: assert property (@(posedge clk) disable iff (!rst_n)
        step < STW'(5));
endmodule

bind loopcnt_cpu loopcnt_cpu_chk #(.DW(DW), .STW(lcc_pkg::STW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .halted     (halted),
    .out_val    (out_val),
    .acc_val    (acc_val),
    .zero_flag  (zero_flag),
    .carry_flag (carry_flag),
    .flag_upd   (flag_upd),
    .out_ld     (out_ld),
    .bus_oe     (bus_oe),
    .step       (s_q.step)
);

// File: tb/tb_loopcnt_cpu.sv
`timescale 1ns/1ps
module tb_loopcnt_cpu;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pl_we = 1'b0;
    logic [3:0] pl_addr = '0;
    logic [7:0] pl_data = '0;
    logic [7:0] out_val, acc_val;
    logic       zero_flag, carry_flag, halted;

    int n_run  = 0;
    int n_fail = 0;
    logic [7:0] prog [16];

    loopcnt_cpu dut (
        .clk(clk), .rst_n(rst_n), .pl_we(pl_we), .pl_addr(pl_addr), .pl_data(pl_data),
        .out_val(out_val), .acc_val(acc_val), .zero_flag(zero_flag),
        .carry_flag(carry_flag), .halted(halted)
    );

    always #2.5 clk = ~clk;

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    function automatic logic [7:0] ins(input logic [3:0] op, input logic [3:0] arg);
        return {op, arg};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_prog();
        for (int k = 0; k < 16; k++) prog[k] = 8'h00;
    endtask

    // Preload under reset (R2), then release and wait for halt
    task automatic run_prog(input string req);
        int cyc;
        @(negedge clk);
        rst_n = 1'b0;
        for (int k = 0; k < 16; k++) begin
            pl_we = 1'b1; pl_addr = 4'(k); pl_data = prog[k];
            @(negedge clk);
        end
        pl_we = 1'b0;
        rst_n = 1'b1;
        cyc = 0;
        while (!halted && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
        chk({req, " halted (R8)"}, int'(halted), 1);
    endtask

    function automatic int fact(input int n);
        int r = 1;
        for (int k = 2; k <= n; k++) r = r * k;
        return r;
    endfunction

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 out", out_val, 0);
        chk("R1 acc", acc_val, 0);
        chk("R1 zf", zero_flag, 0);
        chk("R1 cf", carry_flag, 0);
        chk("R1 halted", halted, 0);

        // R3/R2/R10: moves, OUT only on OUT, NOP and reserved code do nothing
        clear_prog();
        prog[0] = ins(4'h5, 4'd9);
        prog[1] = ins(4'h4, 4'd13);
        prog[2] = ins(4'h5, 4'd3);
        prog[3] = ins(4'hE, 4'd0);
        prog[4] = ins(4'h1, 4'd13);
        prog[5] = ins(4'h0, 4'd0);
        prog[6] = ins(4'hD, 4'd7);
        prog[7] = ins(4'hF, 4'd0);
        run_prog("R3");
        chk("R3 out after OUT", out_val, 3);
        chk("R3 acc from STA/LDA", acc_val, 9);
        chk("R3 flags untouched", {zero_flag, carry_flag}, 0);

        // R5: unconditional jump
        clear_prog();
        prog[0] = ins(4'h6, 4'd3);
        prog[1] = ins(4'h5, 4'd5);
        prog[2] = ins(4'hE, 4'd0);
        prog[3] = ins(4'h5, 4'd7);
        prog[4] = ins(4'hE, 4'd0);
        prog[5] = ins(4'hF, 4'd0);
        run_prog("R5 jmp");
        chk("R5 jmp out", out_val, 7);

        // R4/R5: ALU sweep with flag-driven branches
        begin
            int vals [6] = '{0, 1, 3, 127, 128, 255};
            for (int op = 0; op < 2; op++) begin
                for (int xi = 0; xi < 6; xi++) begin
                    for (int yi = 0; yi < 6; yi++) begin
                        int x, y, r, c, z, ea;
                        x = vals[xi]; y = vals[yi];
                        if (op == 0) begin r = (x + y) & 255; c = (x + y) > 255; end
                        else         begin r = (x - y) & 255; c = (x >= y); end
                        z = (r == 0);
                        ea = c ? 1 : (z ? 2 : r);
                        clear_prog();
                        prog[0] = ins(4'h1, 4'd14);
                        prog[1] = ins(op == 0 ? 4'h2 : 4'h3, 4'd15);
                        prog[2] = ins(4'hE, 4'd0);
                        prog[3] = ins(4'h7, 4'd6);
                        prog[4] = ins(4'h8, 4'd8);
                        prog[5] = ins(4'hF, 4'd0);
                        prog[6] = ins(4'h5, 4'd1);
                        prog[7] = ins(4'hF, 4'd0);
                        prog[8] = ins(4'h5, 4'd2);
                        prog[9] = ins(4'hF, 4'd0);
                        prog[14] = 8'(x);
                        prog[15] = 8'(y);
                        run_prog("R4");
                        chk("R4 result", out_val, r);
                        chk("R4 zero flag", zero_flag, z);
                        chk("R4 carry flag", carry_flag, c);
                        chk("R5 branch on flags", acc_val, ea);
                    end
                end
            end
        end

        // R6/R7: DECJ-driven loop after LDI and MVIJ; ADD flags overwritten by DECJ
        for (int k = 0; k <= 12; k++) begin
            clear_prog();
            prog[0] = ins(4'hB, 4'd15);
            prog[1] = ins(4'hC, 4'd0);
            prog[2] = ins(4'h5, 4'd0);
            prog[3] = ins(4'h2, 4'd14);
            prog[4] = ins(4'hA, 4'd0);
            prog[5] = ins(4'h8, 4'd7);
            prog[6] = ins(4'h6, 4'd3);
            prog[7] = ins(4'hE, 4'd0);
            prog[8] = ins(4'hF, 4'd0);
            prog[14] = 8'd1;
            prog[15] = 8'(k);
            run_prog("R6");
            chk("R6 R7 loop count", out_val, k);
            chk("R6 zero after DECJ", zero_flag, 1);
        end

        // R6: DECI flags
        begin
            int ks [4] = '{0, 1, 2, 255};
            for (int t = 0; t < 4; t++) begin
                clear_prog();
                prog[0] = ins(4'hB, 4'd15);
                prog[1] = ins(4'h9, 4'd0);
                prog[2] = ins(4'h8, 4'd5);
                prog[3] = ins(4'h5, 4'd1);
                prog[4] = ins(4'hF, 4'd0);
                prog[5] = ins(4'h5, 4'd2);
                prog[6] = ins(4'hF, 4'd0);
                prog[15] = 8'(ks[t]);
                run_prog("R6 deci");
                chk("R6 deci zero", zero_flag, int'(ks[t] == 1));
                chk("R6 deci carry", carry_flag, int'(ks[t] != 0));
                chk("R6 deci branch", acc_val, (ks[t] == 1) ? 2 : 1);
            end
        end

        // R9: factorial for N = 1..5
        for (int n = 1; n <= 5; n++) begin
            clear_prog();
            prog[0]  = ins(4'hB, 4'd15);
            prog[1]  = ins(4'h1, 4'd15);
            prog[2]  = ins(4'h9, 4'd0);
            prog[3]  = ins(4'h8, 4'd12);
            prog[4]  = ins(4'h4, 4'd14);
            prog[5]  = ins(4'hC, 4'd0);
            prog[6]  = ins(4'hA, 4'd0);
            prog[7]  = ins(4'h8, 4'd2);
            prog[8]  = ins(4'h2, 4'd14);
            prog[9]  = ins(4'hA, 4'd0);
            prog[10] = ins(4'h8, 4'd2);
            prog[11] = ins(4'h6, 4'd8);
            prog[12] = ins(4'hE, 4'd0);
            prog[13] = ins(4'hF, 4'd0);
            prog[15] = 8'(n);
            run_prog("R9");
            chk("R9 factorial out", out_val, fact(n));
            chk("R9 factorial acc", acc_val, fact(n));
        end

        // R8: halt freezes state
        repeat (40) @(negedge clk);
        chk("R8 still halted", halted, 1);
        chk("R8 out frozen", out_val, 120);
        chk("R8 acc frozen", acc_val, 120);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule